// File: doc/BRIEF.md
# Ticket Lock Arbiter

A lock unit shared by a fixed set of requesting agents that admits them into a critical section strictly in arrival order. An agent asks for the lock by pulsing its acquire line. The unit hands it a ticket, which is the current value of a next-ticket counter, and the counter then moves on by one. A second counter holds the ticket now being served. An agent is granted once its ticket equals that counter. It keeps the grant until it pulses the shared release line, which moves the now-serving counter forward by one.

For every agent the unit also outputs its distance from service: its ticket minus the now-serving count, modulo the counter width. A caller can scale its own backoff from that value. Both counters are TKT_W bits wide and wrap. The agent count must not exceed 2^TKT_W, so that no two outstanding tickets can be equal.

Each agent is tracked by a small state machine with three states:
- SLOT_IDLE: the agent holds no ticket.
- SLOT_QUEUED: the agent holds a ticket and is waiting.
- SLOT_HOLD: the agent is granted.

Its transitions are:
- take (SLOT_IDLE to SLOT_QUEUED): the agent raises acquire.
- serve (SLOT_QUEUED to SLOT_HOLD): its ticket equals the now-serving count.
- drop (SLOT_HOLD to SLOT_IDLE): an accepted release.

Top module: `ticket_lock_arbiter`

## Requirements
- R1: An acquire pulse from an agent in SLOT_IDLE gives it the current next-ticket value. From the next cycle on, that value is on the agent's ticket output and its ticket-valid output is 1. The next-ticket counter then advances by one.
- R2: When several idle agents acquire in the same cycle, they receive consecutive tickets in ascending agent-index order: lowest index first, none duplicated and none skipped.
- R3: An acquire from an agent that already holds a ticket is ignored. Its ticket and state are unchanged and the next-ticket counter does not advance.
- R4: An agent's grant output rises on the first clock edge at which its state is SLOT_QUEUED and its ticket equals the now-serving count. The grant stays high until release, and at most one grant output is high at any time.
- R5: A release pulse while some agent is granted advances the now-serving counter by one. On the same edge it returns the holder to SLOT_IDLE, which drops its grant and ticket-valid.
- R6: Grants are given in ticket order, so agents are served first-come, first-served.
- R7: An agent's distance output is its ticket minus the now-serving count, modulo 2^TKT_W, while it holds a ticket. It is 0 while it holds none.
- R8: Both counters wrap modulo 2^TKT_W, and the ticket order continues across the wrap.
- R9: A release while no agent is granted has no effect on either counter. In that case the error output is 1 for exactly the following cycle. An accepted release leaves the error output at 0.
- R10: After reset both counters are 0, every agent is in SLOT_IDLE, and all outputs are 0. A lone first requester is granted on the second clock edge after its acquire.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acq_i | input | N_AGENTS | Acquire pulse, one bit per agent |
| rel_i | input | 1 | Release pulse from the current holder |
| tkt_vld_o | output | N_AGENTS | Agent holds a ticket |
| tkt_o | output | N_AGENTS*TKT_W | Ticket of each agent, agent i at bits [i*TKT_W +: TKT_W] |
| grant_o | output | N_AGENTS | Agent is inside the critical section |
| dist_o | output | N_AGENTS*TKT_W | Distance to service of each agent, same packing as tkt_o |
| err_o | output | 1 | One-cycle pulse after a release that had no holder |

## Verification
The bench issues same-cycle acquires from several agents. A dispenser that numbered them out of index order, or that gave two of them the same value, would break the ticket comparison and the first-come, first-served scoreboard.

It sends acquires to agents that already hold a ticket. A design that took those would overwrite a live ticket, strand a waiter and advance the counter.

It releases while nobody holds the lock. A design that still advanced now-serving would skip a ticket, so a waiter would never be served; the bench would see this as a missing error pulse and wrong distances.

Long random traffic with 3-bit counters wraps them many times. Wrong modulo arithmetic would show up as wrong distances, a duplicate grant or a broken order.

// File: rtl/lock_pkg.sv
package lock_pkg;
    typedef enum logic [1:0] {
        SLOT_IDLE   = 2'd0,
        SLOT_QUEUED = 2'd1,
        SLOT_HOLD   = 2'd2
    } slot_state_e;
endpackage

// File: rtl/ticket_dispenser.sv
// Next-ticket counter: hands consecutive values to same-cycle takers in index order.
module ticket_dispenser #(
    parameter int N_AGENTS = 4,
    parameter int TKT_W    = 3
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [N_AGENTS-1:0]         take_i,
    output logic [N_AGENTS*TKT_W-1:0]   tkt_for_o
);
    logic [TKT_W-1:0] next_q;
    logic [TKT_W-1:0] next_d;

    always_comb begin
        logic [TKT_W-1:0] run;
        run = next_q;
        for (int i = 0; i < N_AGENTS; i++) begin
            tkt_for_o[i*TKT_W +: TKT_W] = run;
            if (take_i[i]) begin
                run = run + 1'b1;
            end
        end
        next_d = run;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            next_q <= '0;
        end else begin
            next_q <= next_d;
        end
    end
endmodule

// File: rtl/serve_counter.sv
// Now-serving counter with release qualification and error pulse.
module serve_counter #(
    parameter int TKT_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rel_i,
    input  logic             holder_i,
    output logic             rel_ok_o,
    output logic [TKT_W-1:0] serving_o,
    output logic             err_o
);
    logic [TKT_W-1:0] serving_q;
    logic             err_q;

    assign rel_ok_o  = rel_i && holder_i;
    assign serving_o = serving_q;
    assign err_o     = err_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            serving_q <= '0;
            err_q     <= 1'b0;
        end else begin
            err_q <= rel_i && !holder_i;
            if (rel_ok_o) begin
                serving_q <= serving_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ticket_slot.sv
// Per-agent state machine: SLOT_IDLE -> SLOT_QUEUED -> SLOT_HOLD -> SLOT_IDLE.
module ticket_slot
    import lock_pkg::*;
#(
    parameter int TKT_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             acq_i,
    input  logic [TKT_W-1:0] tkt_in_i,
    input  logic [TKT_W-1:0] serving_i,
    input  logic             rel_ok_i,
    output logic             idle_o,
    output logic             hold_o,
    output logic             vld_o,
    output logic [TKT_W-1:0] tkt_o,
    output logic [TKT_W-1:0] dist_o
);
    slot_state_e      st_q;
    slot_state_e      st_d;
    logic [TKT_W-1:0] tkt_q;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= SLOT_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Ticket capture on the take transition
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tkt_q <= '0;
        end else if (st_q == SLOT_IDLE && acq_i) begin
            tkt_q <= tkt_in_i;
        end
    end

    // Transitions: take, serve, drop
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SLOT_IDLE:   if (acq_i)               st_d = SLOT_QUEUED;
            SLOT_QUEUED: if (tkt_q == serving_i)  st_d = SLOT_HOLD;
            SLOT_HOLD:   if (rel_ok_i)            st_d = SLOT_IDLE;
            default:                              st_d = SLOT_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        idle_o = (st_q == SLOT_IDLE);
        hold_o = (st_q == SLOT_HOLD);
        vld_o  = !idle_o;
        tkt_o  = idle_o ? '0 : tkt_q;
        dist_o = idle_o ? '0 : (tkt_q - serving_i);
    end
endmodule

// File: rtl/ticket_lock_arbiter.sv
// Ticket lock: FIFO admission through a next-ticket and a now-serving counter.
// N_AGENTS must not exceed 2**TKT_W.
module ticket_lock_arbiter #(
    parameter int N_AGENTS = 4,
    parameter int TKT_W    = 3
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [N_AGENTS-1:0]       acq_i,
    input  logic                      rel_i,
    output logic [N_AGENTS-1:0]       tkt_vld_o,
    output logic [N_AGENTS*TKT_W-1:0] tkt_o,
    output logic [N_AGENTS-1:0]       grant_o,
    output logic [N_AGENTS*TKT_W-1:0] dist_o,
    output logic                      err_o
);
    localparam int VEC_W = N_AGENTS * TKT_W;

    logic [N_AGENTS-1:0] idle;
    logic [N_AGENTS-1:0] hold;
    logic [N_AGENTS-1:0] take;
    logic [VEC_W-1:0]    tkt_for;
    logic [TKT_W-1:0]    serving;
    logic                rel_ok;

    assign take    = acq_i & idle;
    assign grant_o = hold;

    ticket_dispenser #(.N_AGENTS(N_AGENTS), .TKT_W(TKT_W)) disp_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .take_i    (take),
        .tkt_for_o (tkt_for)
    );

    serve_counter #(.TKT_W(TKT_W)) serve_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rel_i     (rel_i),
        .holder_i  (|hold),
        .rel_ok_o  (rel_ok),
        .serving_o (serving),
        .err_o     (err_o)
    );

    for (genvar g = 0; g < N_AGENTS; g++) begin : g_slot
        ticket_slot #(.TKT_W(TKT_W)) slot_i (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .acq_i     (acq_i[g]),
            .tkt_in_i  (tkt_for[g*TKT_W +: TKT_W]),
            .serving_i (serving),
            .rel_ok_i  (rel_ok),
            .idle_o    (idle[g]),
            .hold_o    (hold[g]),
            .vld_o     (tkt_vld_o[g]),
            .tkt_o     (tkt_o[g*TKT_W +: TKT_W]),
            .dist_o    (dist_o[g*TKT_W +: TKT_W])
        );
    end
endmodule

// File: rtl/ticket_lock_checker.sv
module ticket_lock_checker #(
    parameter int N_AGENTS = 4,
    parameter int TKT_W    = 3
) (
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic [N_AGENTS-1:0]       acq_i,
    input logic                      rel_i,
    input logic [N_AGENTS-1:0]       tkt_vld_o,
    input logic [N_AGENTS*TKT_W-1:0] tkt_o,
    input logic [N_AGENTS-1:0]       grant_o,
    input logic [N_AGENTS*TKT_W-1:0] dist_o,
    input logic                      err_o
);
    // R4
    mutual_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grant_o));

    // R9
    stray_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rel_i && grant_o == '0) |=> err_o);

    // R9
    good_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rel_i && grant_o != '0) |=> !err_o);

    for (genvar g = 0; g < N_AGENTS; g++) begin : g_chk
        // R1
        take_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (acq_i[g] && !tkt_vld_o[g]) |=> tkt_vld_o[g]);

        // R3
        busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (acq_i[g] && tkt_vld_o[g] && !grant_o[g]) |=> $stable(tkt_o[g*TKT_W +: TKT_W]));

        // R5
        drop_on_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (rel_i && grant_o[g]) |=> (!grant_o[g] && !tkt_vld_o[g]));

        // R7
        held_dist_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            grant_o[g] |-> (dist_o[g*TKT_W +: TKT_W] == '0));
    end
endmodule

bind ticket_lock_arbiter ticket_lock_checker #(.N_AGENTS(N_AGENTS), .TKT_W(TKT_W)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acq_i     (acq_i),
    .rel_i     (rel_i),
    .tkt_vld_o (tkt_vld_o),
    .tkt_o     (tkt_o),
    .grant_o   (grant_o),
    .dist_o    (dist_o),
    .err_o     (err_o)
);

// File: tb/ticket_lock_arbiter_tb_top.sv
`timescale 1ns/1ps
module ticket_lock_arbiter_tb_top;
    localparam int N = 4;
    localparam int W = 3;
    localparam real HALF = 2.0;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   acq_i = '0;
    logic           rel_i = 1'b0;
    logic [N-1:0]   tkt_vld_o;
    logic [N*W-1:0] tkt_o;
    logic [N-1:0]   grant_o;
    logic [N*W-1:0] dist_o;
    logic           err_o;

    always #(HALF) clk = ~clk;

    ticket_lock_arbiter #(.N_AGENTS(N), .TKT_W(W)) dut_i (
        .clk_i (clk), .rst_ni (rst_n), .acq_i (acq_i), .rel_i (rel_i),
        .tkt_vld_o (tkt_vld_o), .tkt_o (tkt_o), .grant_o (grant_o),
        .dist_o (dist_o), .err_o (err_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference model, built from the requirements
    bit           busy [N];
    logic [W-1:0] mtkt [N];
    logic [W-1:0] mnext = '0;
    logic [W-1:0] mserv = '0;
    bit           exp_err = 0;
    int           order_q [$];
    logic [N-1:0] prev_grant = '0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        for (int i = 0; i < N; i++) begin
            logic [W-1:0] et;
            logic [W-1:0] ed;
            et = busy[i] ? mtkt[i] : '0;
            ed = busy[i] ? (mtkt[i] - mserv) : '0;
            check(tkt_vld_o[i] == busy[i], "R5 ticket-valid", tkt_vld_o[i], busy[i]);
            check(tkt_o[i*W +: W] == et, "R1 R8 ticket", tkt_o[i*W +: W], et);
            check(dist_o[i*W +: W] == ed, "R7 distance", dist_o[i*W +: W], ed);
            if (grant_o[i])
                check(busy[i] && mtkt[i] == mserv, "R4 grant on match", mtkt[i], mserv);
        end
        check(err_o == exp_err, "R9 error pulse", err_o, exp_err);
    endtask

    // Driver: apply one cycle of stimulus and push expected items
    task automatic step(input logic [N-1:0] m, input bit r);
        @(negedge clk);
        acq_i = m;
        rel_i = r;
        for (int i = 0; i < N; i++) begin
            if (m[i] && !busy[i]) begin
                busy[i] = 1;
                mtkt[i] = mnext;
                mnext   = mnext + 1'b1;
                order_q.push_back(i);
            end
        end
        exp_err = 0;
        if (r) begin
            if (grant_o != '0) begin
                for (int i = 0; i < N; i++) if (grant_o[i]) busy[i] = 0;
                mserv = mserv + 1'b1;
            end else begin
                exp_err = 1;
            end
        end
        @(posedge clk);
        #0.5;
        acq_i = '0;
        rel_i = 1'b0;
        @(negedge clk);
        check_all();
    endtask

    // Monitor: mutual exclusion and FIFO grant order
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check($countones(grant_o) <= 1, "R4 mutual exclusion", $countones(grant_o), 1);
            if (grant_o != '0 && grant_o != prev_grant) begin
                int who;
                int exp_who;
                who = 0;
                for (int i = 0; i < N; i++) if (grant_o[i]) who = i;
                exp_who = (order_q.size() > 0) ? order_q.pop_front() : -1;
                check(who == exp_who, "R6 FIFO order", who, exp_who);
            end
            prev_grant = grant_o;
        end
    end

    initial begin
        #(4.0 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin busy[i] = 0; mtkt[i] = '0; end
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        check(tkt_vld_o == '0 && grant_o == '0 && err_o == 0 && tkt_o == '0 && dist_o == '0,
              "R10 reset outputs", int'(grant_o), 0);
        rst_n = 1'b1;

        // R1 / R10: lone first requester
        step(4'b0001, 0);
        @(negedge clk);
        check(grant_o == 4'b0001, "R10 first grant", grant_o, 1);
        // R3: agent 0 busy, agent 1 new
        step(4'b0011, 0);
        // R2: two same-cycle acquirers in index order
        step(4'b1100, 0);
        check(tkt_o[3*W +: W] == 3'd3, "R2 index order", tkt_o[3*W +: W], 3);
        // R5: release advances the queue
        step(4'b0000, 1);
        @(negedge clk);
        check(grant_o == 4'b0010, "R5 next holder", grant_o, 2);
        // drain
        while (busy[0] || busy[1] || busy[2] || busy[3])
            step('0, grant_o != '0);
        // R9: stray release
        step('0, 1);
        step(4'b0100, 0);
        @(negedge clk);
        check(grant_o == 4'b0100, "R9 counters untouched", grant_o, 4);

        // Random traffic, counters wrap many times (R8)
        for (int k = 0; k < 600; k++) begin
            logic [N-1:0] m;
            bit r;
            m = N'($urandom);
            r = ($urandom_range(0, 2) == 0);
            step(m, r);
        end
        while (busy[0] || busy[1] || busy[2] || busy[3])
            step('0, grant_o != '0);
        repeat (3) @(negedge clk);
        check(order_q.size() == 0, "R6 all served", order_q.size(), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule